// File: doc/BRIEF.md
# DRAM Command Spacing Checker

This block observes the decoded command stream of one DDR3-style rank. It takes at most one command per controller clock, together with its bank address. For every command it checks the minimum spacing rules against earlier commands. A command that arrives too early is reported on the following clock as a violation flag plus a one-hot code. The code names each rule that was broken, and several rules may be broken by the same command.

Every spacing limit is an elaboration-time constant, measured in clocks. Limits given in picoseconds are converted by rounding up the ratio to the clock period. Where a rule also has a floor in clocks, the larger of the two values applies. A command counts as legal once that many clock edges have passed, whatever the jitter does to real time.

The rules covered are:
- column-to-column spacing;
- activate-to-activate spacing across banks;
- the rolling four-activate window;
- read-to-precharge spacing per bank;
- write-to-read turnaround, measured from the internal start of the write;
- the two mode-register spacings.

The block only observes. It never blocks or changes a command, and every issued command updates the tracking, including one that was flagged.

Top module: `dram_cmd_spacing_chk`

## Requirements
- R1: During reset and on the first clock after it, `viol_o` is 0 and `viol_code_o` is all zeros. After reset every tracker counts as long expired, so the first command of each type is never flagged.
- R2: Command encoding on `cmd_i`: 0 idle, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 MRS; values 6 and 7 are treated as idle. The result for a command at clock edge t appears on `viol_code_o` after edge t+1. The code bits are: bit0 column spacing, bit1 activate spacing, bit2 activate window, bit3 read-to-precharge, bit4 write-to-read, bit5 MRS-to-MRS, bit6 MRS-to-other. `viol_o` is the OR of the code bits, and idle cycles never raise any bit.
- R3: An RD or WR issued fewer than 4 clocks after the previous RD or WR sets bit0. Any mix of RD and WR counts.
- R4: An ACT issued fewer than max(4, ceil(tRRD/tCK)) clocks after the previous ACT, to a different bank, sets bit1. tRRD is 6 ns for a 1 KB page and 7.5 ns for a 2 KB page. An ACT to the same bank as the previous ACT never sets bit1.
- R5: An ACT issued fewer than ceil(tFAW/tCK) clocks after the fourth-most-recent ACT sets bit2. tFAW is 30 ns for a 1 KB page and 45 ns for a 2 KB page.
- R6: A PRE to bank b issued fewer than max(4, ceil(7.5 ns/tCK)) clocks after the last RD to bank b sets bit3. A RD to another bank has no effect, and only PRE can set bit3.
- R7: An RD issued fewer than WL + D + max(4, ceil(7.5 ns/tCK)) clocks after the last WR sets bit4. D is 4 for 8-beat bursts and on-the-fly chop, and 2 when chop-4 is fixed. Only RD can set bit4.
- R8: An MRS issued fewer than 4 clocks after the previous MRS sets bit5.
- R9: An ACT, RD, WR or PRE issued fewer than max(12, ceil(15 ns/tCK)) clocks after the last MRS sets bit6.
- R10: A flagged command still updates its trackers, and one command may set several code bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command type for this clock |
| bank_i | input | BANK_W | Bank address of the command |
| viol_o | output | 1 | Some spacing rule was broken by the previous clock's command |
| viol_code_o | output | 7 | One-hot-per-rule violation bits for the previous clock's command |

## Verification
The hardest case to reach from the ports is a fifth activate that breaks only the four-activate window. Every activate before it has to respect the activate-to-activate spacing, so that bit1 does not mask the result. The bench therefore places four activates to distinct banks, each one clock beyond that spacing, and then sweeps the offset of a fifth activate across both the window edge and the pairwise edge. The expected code is computed from both limits. Before each trial the bench runs an idle stretch longer than every limit, so each trial starts from expired trackers.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5
  } cmd_e;

  localparam int V_CCD = 0;
  localparam int V_RRD = 1;
  localparam int V_FAW = 2;
  localparam int V_RTP = 3;
  localparam int V_WTR = 4;
  localparam int V_MRD = 5;
  localparam int V_MOD = 6;
  localparam int NUM_V = 7;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dcs_gap_cnt.sv
// Clocks elapsed since the last hit; reset and idle value is saturated (expired).
module dcs_gap_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  output logic [CNT_W-1:0] gap_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_o <= SAT;
    else if (hit_i)       gap_o <= CNT_W'(1);
    else if (gap_o != SAT) gap_o <= gap_o + 1'b1;
  end
endmodule

// File: rtl/dcs_act_window.sv
// Ages of the last DEPTH activates, newest in slot 0.
module dcs_act_window #(
  parameter int CNT_W = 5,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  output logic [CNT_W-1:0] oldest_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [DEPTH-1:0][CNT_W-1:0] age_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == SAT) ? SAT : v + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= {DEPTH{SAT}};
    end else begin
      for (int i = DEPTH - 1; i > 0; i--)
        age_q[i] <= act_i ? sat_inc(age_q[i-1]) : sat_inc(age_q[i]);
      age_q[0] <= act_i ? CNT_W'(1) : sat_inc(age_q[0]);
    end
  end

  assign oldest_o = age_q[DEPTH-1];
endmodule

// File: rtl/dram_cmd_spacing_chk.sv
module dram_cmd_spacing_chk
  import dcs_pkg::*;
#(
  parameter int BANK_W      = 3,
  parameter int TCK_PS      = 1500,
  parameter bit PAGE_2KB    = 1'b0,
  parameter int WL          = 7,
  parameter bit BC4_FIXED   = 1'b0,
  parameter int TRRD_1K_PS  = 6000,
  parameter int TRRD_2K_PS  = 7500,
  parameter int TFAW_1K_PS  = 30000,
  parameter int TFAW_2K_PS  = 45000,
  parameter int TRTP_PS     = 7500,
  parameter int TWTR_PS     = 7500,
  parameter int TMOD_PS     = 15000,
  parameter int ACT_WINDOW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              viol_o,
  output logic [NUM_V-1:0]  viol_code_o
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int L_CCD   = 4;
  localparam int L_MRD   = 4;
  localparam int L_RRD   = imax(4, ceil_div(PAGE_2KB ? TRRD_2K_PS : TRRD_1K_PS, TCK_PS));
  localparam int L_FAW   = ceil_div(PAGE_2KB ? TFAW_2K_PS : TFAW_1K_PS, TCK_PS);
  localparam int L_RTP   = imax(4, ceil_div(TRTP_PS, TCK_PS));
  localparam int WR_LEAD = WL + (BC4_FIXED ? 2 : 4);
  localparam int L_WTR   = WR_LEAD + imax(4, ceil_div(TWTR_PS, TCK_PS));
  localparam int L_MOD   = imax(12, ceil_div(TMOD_PS, TCK_PS));
  localparam int LIM_MAX = imax(imax(imax(L_CCD, L_RRD), imax(L_FAW, L_RTP)),
                                imax(imax(L_WTR, L_MOD), L_MRD));
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic is_act, is_rd, is_wr, is_pre, is_mrs, is_col, is_cmd;
  assign is_act = (cmd_i == CMD_ACT);
  assign is_rd  = (cmd_i == CMD_RD);
  assign is_wr  = (cmd_i == CMD_WR);
  assign is_pre = (cmd_i == CMD_PRE);
  assign is_mrs = (cmd_i == CMD_MRS);
  assign is_col = is_rd | is_wr;
  assign is_cmd = is_act | is_col | is_pre;

  logic [CNT_W-1:0] col_gap, act_gap, wr_gap, mrs_gap, faw_oldest;
  logic [NUM_BANKS-1:0][CNT_W-1:0] rd_gap;

  dcs_gap_cnt #(.CNT_W(CNT_W)) u_col (.clk_i, .rst_ni, .hit_i(is_col), .gap_o(col_gap));
  dcs_gap_cnt #(.CNT_W(CNT_W)) u_act (.clk_i, .rst_ni, .hit_i(is_act), .gap_o(act_gap));
  dcs_gap_cnt #(.CNT_W(CNT_W)) u_wr  (.clk_i, .rst_ni, .hit_i(is_wr),  .gap_o(wr_gap));
  dcs_gap_cnt #(.CNT_W(CNT_W)) u_mrs (.clk_i, .rst_ni, .hit_i(is_mrs), .gap_o(mrs_gap));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dcs_gap_cnt #(.CNT_W(CNT_W)) u_rd (
      .clk_i, .rst_ni,
      .hit_i (is_rd && (bank_i == BANK_W'(b))),
      .gap_o (rd_gap[b])
    );
  end

  dcs_act_window #(.CNT_W(CNT_W), .DEPTH(ACT_WINDOW)) u_faw (
    .clk_i, .rst_ni, .act_i(is_act), .oldest_o(faw_oldest)
  );

  logic [BANK_W-1:0] act_bank_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_bank_q <= '0;
    else if (is_act) act_bank_q <= bank_i;
  end

  logic [NUM_V-1:0] viol_d;
  always_comb begin
    viol_d        = '0;
    viol_d[V_CCD] = is_col && (col_gap < CNT_W'(L_CCD));
    viol_d[V_RRD] = is_act && (bank_i != act_bank_q) && (act_gap < CNT_W'(L_RRD));
    viol_d[V_FAW] = is_act && (faw_oldest < CNT_W'(L_FAW));
    viol_d[V_RTP] = is_pre && (rd_gap[bank_i] < CNT_W'(L_RTP));
    viol_d[V_WTR] = is_rd  && (wr_gap < CNT_W'(L_WTR));
    viol_d[V_MRD] = is_mrs && (mrs_gap < CNT_W'(L_MRD));
    viol_d[V_MOD] = is_cmd && (mrs_gap < CNT_W'(L_MOD));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_code_o <= '0;
      viol_o      <= 1'b0;
    end else begin
      viol_code_o <= viol_d;
      viol_o      <= |viol_d;
    end
  end
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk
  import dcs_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              viol_o,
  input logic [NUM_V-1:0]  viol_code_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic up, is_col, is_act, is_mrs, is_cmd, is_idle;
  assign up      = (age_q == 2'd3);
  assign is_col  = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign is_act  = (cmd_i == CMD_ACT);
  assign is_mrs  = (cmd_i == CMD_MRS);
  assign is_cmd  = is_col || is_act || (cmd_i == CMD_PRE);
  assign is_idle = !is_cmd && !is_mrs;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && is_idle) |=> (viol_code_o == '0)); // R2
  AST_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o == (viol_code_o != '0)); // R2
  AST_CCD_B2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && is_col && ($past(cmd_i) == CMD_RD || $past(cmd_i) == CMD_WR))
      |=> viol_code_o[V_CCD]); // R3
  AST_RRD_B2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && is_act && $past(cmd_i) == CMD_ACT && bank_i != $past(bank_i))
      |=> viol_code_o[V_RRD]); // R4
  AST_RTP_ONLY_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && cmd_i != CMD_PRE) |=> !viol_code_o[V_RTP]); // R6
  AST_WTR_ONLY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && cmd_i != CMD_RD) |=> !viol_code_o[V_WTR]); // R7
  AST_MRD_B2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && is_mrs && $past(cmd_i) == CMD_MRS) |=> viol_code_o[V_MRD]); // R8
  AST_MOD_B2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && is_cmd && $past(cmd_i) == CMD_MRS) |=> viol_code_o[V_MOD]); // R9
endmodule

bind dram_cmd_spacing_chk dcs_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .bank_i      (bank_i),
  .viol_o      (viol_o),
  .viol_code_o (viol_code_o)
);

// File: tb/sim_dram_cmd_spacing_chk.sv
`timescale 1ns/1ps
module sim_dram_cmd_spacing_chk;
  localparam int TCK = 1500;
  localparam int WLC = 7;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_CCD = 4;
  localparam int E_MRD = 4;
  localparam int E_RRD = mx(4, cdiv(6000, TCK));
  localparam int E_FAW = cdiv(30000, TCK);
  localparam int E_RTP = mx(4, cdiv(7500, TCK));
  localparam int E_WTR = WLC + 4 + mx(4, cdiv(7500, TCK));
  localparam int E_MOD = mx(12, cdiv(15000, TCK));
  localparam int FLUSH = 40;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_MRS = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [2:0] bank = 3'd0;
  logic viol;
  logic [6:0] code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_cmd_spacing_chk #(.BANK_W(3), .TCK_PS(TCK), .PAGE_2KB(1'b0), .WL(WLC),
                         .BC4_FIXED(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank),
    .viol_o(viol), .viol_code_o(code)
  );

  task automatic check(input string req, input logic [6:0] got, input logic got_f,
                       input logic [6:0] exp);
    n_chk++;
    if (got !== exp || got_f !== (exp != 7'd0)) begin
      n_fail++;
      $display("FAIL %s code=%b flag=%b expected code=%b flag=%b",
               req, got, got_f, exp, exp != 7'd0);
    end
  endtask

  // Entered at a negedge; returns the code reported for this command.
  task automatic issue(input logic [2:0] c, input logic [2:0] b,
                       output logic [6:0] got, output logic got_f);
    cmd = c;
    bank = b;
    @(negedge clk);
    got = code;
    got_f = viol;
    cmd = C_NOP;
  endtask

  task automatic idle(input int n);
    logic [6:0] g;
    logic f;
    for (int i = 0; i < n; i++) issue(C_NOP, 3'd0, g, f);
  endtask

  task automatic pair(input string req, input logic [2:0] c1, input logic [2:0] b1,
                      input logic [2:0] c2, input logic [2:0] b2, input int gap,
                      input logic [6:0] exp);
    logic [6:0] g;
    logic f;
    idle(FLUSH);
    issue(c1, b1, g, f);
    idle(gap - 1);
    issue(c2, b2, g, f);
    check(req, g, f, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] g;
    logic f;
    logic [6:0] e;
    repeat (3) @(negedge clk);
    check("R1 in reset", code, viol, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", code, viol, 7'd0);

    // R1: first command of each type is never flagged
    issue(C_MRS, 3'd0, g, f); check("R1 first MRS", g, f, 7'd0);
    idle(20);
    issue(C_ACT, 3'd1, g, f); check("R1 first ACT", g, f, 7'd0);
    idle(20);
    issue(C_WR, 3'd1, g, f);  check("R1 first WR", g, f, 7'd0);
    idle(30);
    issue(C_RD, 3'd1, g, f);  check("R1 first RD", g, f, 7'd0);
    idle(20);
    issue(C_PRE, 3'd1, g, f); check("R1 first PRE", g, f, 7'd0);

    // R2: idle and reserved codes right after MRS are not flagged
    idle(FLUSH);
    issue(C_MRS, 3'd0, g, f);
    issue(3'd6, 3'd0, g, f); check("R2 reserved 6", g, f, 7'd0);
    issue(3'd7, 3'd0, g, f); check("R2 reserved 7", g, f, 7'd0);
    issue(C_NOP, 3'd0, g, f); check("R2 idle", g, f, 7'd0);

    // R3 / R7: column pairs
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int gp = 1; gp <= 6; gp++) begin
          e = '0;
          e[0] = (gp < E_CCD);
          e[4] = (a == 1 && b == 0 && gp < E_WTR);
          pair("R3 column spacing", a ? C_WR : C_RD, 3'd0, b ? C_WR : C_RD, 3'd3, gp, e);
        end
    for (int gp = 1; gp <= E_WTR + 2; gp++) begin
      e = '0;
      e[0] = (gp < E_CCD);
      e[4] = (gp < E_WTR);
      pair("R7 write to read", C_WR, 3'd2, C_RD, 3'd5, gp, e);
    end
    for (int gp = 1; gp <= 6; gp++) begin
      e = '0;
      e[0] = (gp < E_CCD);
      pair("R7 write to write no turnaround", C_WR, 3'd2, C_WR, 3'd2, gp, e);
    end

    // R4: activate spacing
    for (int gp = 1; gp <= 6; gp++) begin
      e = '0;
      e[1] = (gp < E_RRD);
      pair("R4 act diff bank", C_ACT, 3'd0, C_ACT, 3'd1, gp, e);
    end
    for (int gp = 1; gp <= 3; gp++)
      pair("R4 act same bank", C_ACT, 3'd4, C_ACT, 3'd4, gp, 7'd0);

    // R5: four-activate window, fifth ACT offset sweep
    for (int gp = 1; gp <= 8; gp++) begin
      idle(FLUSH);
      for (int k = 0; k < 4; k++) begin
        issue(C_ACT, 3'(k), g, f);
        check("R5 leading act", g, f, 7'd0);
        if (k < 3) idle(E_RRD);
      end
      idle(gp - 1);
      issue(C_ACT, 3'd4, g, f);
      e = '0;
      e[1] = (gp < E_RRD);
      e[2] = (3 * (E_RRD + 1) + gp < E_FAW);
      check("R5 fifth act", g, f, e);
    end

    // R6: read to precharge
    for (int gp = 1; gp <= E_RTP + 2; gp++) begin
      e = '0;
      e[3] = (gp < E_RTP);
      pair("R6 read to pre same bank", C_RD, 3'd2, C_PRE, 3'd2, gp, e);
    end
    pair("R6 read to pre other bank", C_RD, 3'd2, C_PRE, 3'd5, 1, 7'd0);

    // R8: MRS spacing
    for (int gp = 1; gp <= 6; gp++) begin
      e = '0;
      e[5] = (gp < E_MRD);
      pair("R8 mrs to mrs", C_MRS, 3'd0, C_MRS, 3'd0, gp, e);
    end

    // R9: MRS to any other command
    for (int c = 1; c <= 4; c++)
      for (int gp = 1; gp <= E_MOD + 2; gp++) begin
        e = '0;
        e[6] = (gp < E_MOD);
        pair("R9 mrs to command", C_MRS, 3'd0, 3'(c), 3'd6, gp, e);
      end

    // R10: flagged command still updates its tracker
    idle(FLUSH);
    issue(C_RD, 3'd0, g, f);
    issue(C_RD, 3'd0, g, f); check("R10 second read flagged", g, f, 7'b0000001);
    idle(2);
    issue(C_RD, 3'd0, g, f); check("R10 tracker moved by flagged read", g, f, 7'b0000001);
    // R10: several bits at once
    idle(FLUSH);
    issue(C_MRS, 3'd0, g, f);
    issue(C_WR, 3'd0, g, f);
    issue(C_RD, 3'd0, g, f); check("R10 multi-bit", g, f, 7'b1010001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule